// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a short run of instruction bytes fetched ahead of execution. It sits between a 16-bit code-fetch bus port and a byte-wide consumer on the execution side. It decides on its own when to start a code fetch. It tracks the next fetch address and stores the one or two bytes that each completed fetch returns. The consumer takes those bytes one at a time, oldest first.

A fetch to an even address returns a whole aligned word, so both bytes go into the queue. A fetch to an odd address returns only the byte on the upper lane. After that odd fetch, the fetch address is aligned again.

When the execution side transfers control, it pulses a flush with the new target address. The queue empties and fetching restarts from the target. The execution side can also ask for the bus to move an operand. Code fetches then stop issuing, but a fetch that is already under way finishes first.

On every clock the block reports a two-bit code that says what happened to the queue on the edge just past.

Top module: `code_prefetch_queue`

## Requirements
- R1: After reset the queue is empty, no fetch is pending and the status code is 00. The first fetch issued after reset is a word fetch at the reset address parameter (default 0x0000).
- R2: A fetch is issued only when at least two byte slots are free, no operand request is present and no flush is present in that cycle. Once issued, the request and its address stay unchanged until the cycle in which the bus signals completion.
- R3: A fetch to an even address is a word fetch. Bits 7:0 of the returned data enter the queue first, then bits 15:8, and the fetch address advances by 2.
- R4: A fetch to an odd address is a byte fetch. Only bits 15:8 of the returned data enter the queue, and the fetch address advances by 1.
- R5: Each read taken while the queue holds data removes exactly one byte, the oldest one. A read while the queue is empty is ignored: no byte is removed and the status code is 00.
- R6: The queue never holds more than DEPTH bytes (default 6). With fetching left free, it fills to 6 bytes from an even start address and to 5 bytes from an odd one.
- R7: A flush empties the queue on the next edge, and the following fetches start at the flush target address.
- R8: Bytes returned by a fetch that was in progress when a flush occurred, or that completes in the flush cycle, are discarded.
- R9: An operand request is granted only while no fetch is pending. A pending fetch completes before the grant appears.
- R10: The status code is registered and describes the previous edge. 10 means a flush (this wins over a read in the same cycle), 01 means a byte was taken as the first byte of an instruction, 11 means a byte was taken as a later byte, and 00 means no queue operation.
- R11: The fetch address wraps within 16 bits. A byte fetch at 0xFFFF is followed by a word fetch at 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req_o | output | 1 | Code fetch pending |
| fetch_addr_o | output | AW | Address of the pending fetch |
| fetch_word_o | output | 1 | 1 = two-byte fetch, 0 = upper-lane byte fetch |
| fetch_done_i | input | 1 | Bus completes the pending fetch this cycle |
| fetch_data_i | input | 16 | Data returned with the completion |
| opr_req_i | input | 1 | Execution side requests an operand bus cycle |
| opr_grant_o | output | 1 | Operand cycle may start |
| flush_i | input | 1 | Control transfer: empty the queue |
| flush_addr_i | input | AW | New fetch target on a flush |
| rd_i | input | 1 | Consumer takes a byte |
| first_i | input | 1 | Byte being taken opens an instruction |
| avail_o | output | 1 | Queue holds at least one byte |
| rd_byte_o | output | 8 | Oldest byte in the queue |
| qs_o | output | 2 | Queue operation code for the previous edge |

## Verification
A wrong read or write pointer shows up as an out-of-sequence byte on rd_byte_o at the very next read. The bench checks every byte taken against the byte value it expects at the running fetch address. A wrong occupancy count or wrong room test shows up as a fill level other than 6 or 5 once fetching has been held off and the queue is drained. A stale in-flight fetch that was not dropped, or a wrong address after a flush or wrap, appears as a wrong first byte after the control transfer. A late or misencoded status code differs from the expected code one cycle after the operation.

// File: rtl/cpq_pkg.sv
package cpq_pkg;
  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qs_e;
endpackage

// File: rtl/cpq_store.sv
module cpq_store #(
  parameter int DEPTH = 6,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_en,
  input  logic          wr_two,
  input  logic [7:0]    wr_b0,
  input  logic [7:0]    wr_b1,
  input  logic          rd_en,
  output logic [7:0]    head_o,
  output logic [CW-1:0] occ_o
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] hd_q, tl_q, tl1;
  logic [CW-1:0] occ_q, add_n;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign tl1   = bump(tl_q);
  assign add_n = wr_en ? (wr_two ? CW'(2) : CW'(1)) : '0;

  // Storage array: no reset, so it can map onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[tl_q] <= wr_b0;
      if (wr_two) mem[tl1] <= wr_b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      hd_q  <= '0;
      tl_q  <= '0;
      occ_q <= '0;
    end else begin
      if (wr_en) tl_q <= wr_two ? bump(tl1) : tl1;
      if (rd_en) hd_q <= bump(hd_q);
      occ_q <= occ_q + add_n - CW'(rd_en);
    end
  end

  assign head_o = mem[hd_q];
  assign occ_o  = occ_q;
endmodule

// File: rtl/cpq_fetch.sv
module cpq_fetch #(
  parameter int              DEPTH      = 6,
  parameter int              AW         = 16,
  parameter logic [AW-1:0]   RESET_ADDR = '0,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  input  logic          opr_req,
  input  logic [CW-1:0] occ,
  input  logic          done,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          wr_en_o,
  output logic          wr_two_o,
  output logic          grant_o
);
  localparam logic [CW-1:0] ROOM_LIM = CW'(DEPTH - 2);

  logic          busy_q, drop_q;
  logic [AW-1:0] pc_q, fa_q;
  logic          has_room;

  assign has_room = (occ <= ROOM_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      drop_q <= 1'b0;
      pc_q   <= RESET_ADDR;
      fa_q   <= RESET_ADDR;
    end else begin
      if (flush) pc_q <= flush_addr;
      if (busy_q) begin
        if (done) begin
          busy_q <= 1'b0;
          drop_q <= 1'b0;
        end else if (flush) begin
          drop_q <= 1'b1;
        end
      end else if (!flush && !opr_req && has_room) begin
        busy_q <= 1'b1;
        fa_q   <= pc_q;
        pc_q   <= pc_q + (pc_q[0] ? AW'(1) : AW'(2));
      end
    end
  end

  assign req_o    = busy_q;
  assign addr_o   = fa_q;
  assign wr_two_o = ~fa_q[0];
  assign wr_en_o  = busy_q & done & ~drop_q & ~flush;
  assign grant_o  = opr_req & ~busy_q;
endmodule

// File: rtl/cpq_status.sv
module cpq_status
  import cpq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic       take,
  input  logic       first,
  output logic [1:0] qs_o
);
  qs_e qs_q;

  always_ff @(posedge clk) begin
    if (rst)        qs_q <= QS_IDLE;
    else if (flush) qs_q <= QS_FLUSH;
    else if (take)  qs_q <= first ? QS_FIRST : QS_NEXT;
    else            qs_q <= QS_IDLE;
  end

  assign qs_o = qs_q;
endmodule

// File: rtl/code_prefetch_queue.sv
module code_prefetch_queue #(
  parameter int            DEPTH      = 6,
  parameter int            AW         = 16,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  output logic          fetch_req_o,
  output logic [AW-1:0] fetch_addr_o,
  output logic          fetch_word_o,
  input  logic          fetch_done_i,
  input  logic [15:0]   fetch_data_i,
  input  logic          opr_req_i,
  output logic          opr_grant_o,
  input  logic          flush_i,
  input  logic [AW-1:0] flush_addr_i,
  input  logic          rd_i,
  input  logic          first_i,
  output logic          avail_o,
  output logic [7:0]    rd_byte_o,
  output logic [1:0]    qs_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] occ_w;
  logic          wr_en, wr_two, take;
  logic [7:0]    b0, b1;

  assign avail_o = (occ_w != '0);
  assign take    = rd_i & avail_o & ~flush_i;
  // Odd fetches return their byte on the upper lane
  assign b0      = wr_two ? fetch_data_i[7:0] : fetch_data_i[15:8];
  assign b1      = fetch_data_i[15:8];

  cpq_fetch #(.DEPTH(DEPTH), .AW(AW), .RESET_ADDR(RESET_ADDR)) u_fetch (
    .clk(clk), .rst(rst), .flush(flush_i), .flush_addr(flush_addr_i),
    .opr_req(opr_req_i), .occ(occ_w), .done(fetch_done_i),
    .req_o(fetch_req_o), .addr_o(fetch_addr_o), .wr_en_o(wr_en),
    .wr_two_o(wr_two), .grant_o(opr_grant_o)
  );

  cpq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .flush(flush_i), .wr_en(wr_en), .wr_two(wr_two),
    .wr_b0(b0), .wr_b1(b1), .rd_en(take), .head_o(rd_byte_o), .occ_o(occ_w)
  );

  cpq_status u_status (
    .clk(clk), .rst(rst), .flush(flush_i), .take(take), .first(first_i),
    .qs_o(qs_o)
  );

  assign fetch_word_o = wr_two;
endmodule

// File: rtl/cpq_checker.sv
module cpq_checker #(
  parameter int DEPTH = 6,
  parameter int AW    = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          flush_i,
  input logic          opr_req_i,
  input logic          fetch_req_o,
  input logic          fetch_done_i,
  input logic [AW-1:0] fetch_addr_o,
  input logic          opr_grant_o,
  input logic          avail_o,
  input logic [1:0]    qs_o,
  input logic [CW-1:0] occ
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fetch_req_o && !fetch_done_i) |=> (fetch_req_o && $stable(fetch_addr_o))); // R2
  AST_NO_START_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!fetch_req_o && (opr_req_i || flush_i)) |=> !fetch_req_o); // R2
  AST_START_ROOM: assert property (@(posedge clk) disable iff (rst)
    $rose(fetch_req_o) |-> (int'(occ) <= DEPTH - 2)); // R2
  AST_CAPACITY: assert property (@(posedge clk) disable iff (rst)
    int'(occ) <= DEPTH); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flush_i)) |-> !avail_o); // R7
  AST_GRANT_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
    (fetch_req_o && fetch_done_i && opr_req_i) |=> (opr_grant_o || !opr_req_i)); // R9
  AST_QS_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flush_i)) |-> (qs_o == 2'b10)); // R10
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(flush_i) && !$past(avail_o)) |-> (qs_o == 2'b00)); // R5
endmodule

bind code_prefetch_queue cpq_checker #(.DEPTH(DEPTH), .AW(AW)) u_cpq_checker (
  .clk(clk), .rst(rst), .flush_i(flush_i), .opr_req_i(opr_req_i),
  .fetch_req_o(fetch_req_o), .fetch_done_i(fetch_done_i),
  .fetch_addr_o(fetch_addr_o), .opr_grant_o(opr_grant_o),
  .avail_o(avail_o), .qs_o(qs_o), .occ(occ_w)
);

// File: tb/code_prefetch_queue_bench.sv
module code_prefetch_queue_bench;
  localparam int DEPTH = 6;
  localparam int AW    = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          fetch_req_o, fetch_word_o, opr_grant_o, avail_o;
  logic [AW-1:0] fetch_addr_o;
  logic          fetch_done_i = 1'b0;
  logic [15:0]   fetch_data_i = '0;
  logic          opr_req_i = 1'b0, flush_i = 1'b0, rd_i = 1'b0, first_i = 1'b0;
  logic [AW-1:0] flush_addr_i = '0;
  logic [7:0]    rd_byte_o;
  logic [1:0]    qs_o;

  code_prefetch_queue #(.DEPTH(DEPTH), .AW(AW)) u_code_prefetch_queue (
    .clk(clk), .rst(rst), .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
    .fetch_word_o(fetch_word_o), .fetch_done_i(fetch_done_i),
    .fetch_data_i(fetch_data_i), .opr_req_i(opr_req_i), .opr_grant_o(opr_grant_o),
    .flush_i(flush_i), .flush_addr_i(flush_addr_i), .rd_i(rd_i), .first_i(first_i),
    .avail_o(avail_o), .rd_byte_o(rd_byte_o), .qs_o(qs_o)
  );

  int compared = 0;
  int mismatched = 0;
  int lat = 1;
  int wcnt = 0;

  function automatic logic [7:0] mbyte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic int fill_of(input logic [15:0] s);
    int f = 0;
    logic [15:0] a = s;
    while (DEPTH - f >= 2) begin
      f += a[0] ? 1 : 2;
      a += a[0] ? 16'd1 : 16'd2;
    end
    return f;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Bus model: completes a pending fetch after lat idle cycles
  always @(negedge clk) begin
    if (rst) begin
      fetch_done_i = 1'b0;
      wcnt = 0;
    end else if (fetch_done_i) begin
      fetch_done_i = 1'b0;
    end else if (fetch_req_o) begin
      if (wcnt >= lat) begin
        fetch_done_i = 1'b1;
        fetch_data_i = {mbyte(fetch_addr_o | 16'h1), mbyte(fetch_addr_o & 16'hFFFE)};
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end
  end

  logic [15:0] exp_pc = '0;
  int          exp_qs = 0;
  bit          p_opr = 0, p_block = 0, p_req = 0, p_fl = 0;

  task automatic cyc(input bit rd, input bit first, input bit fl,
                     input logic [15:0] tgt, input bit opr, output bit took);
    @(negedge clk);
    check("R10 status code", qs_o, exp_qs);
    if (p_opr) check("R9 grant only when no fetch pending", opr_grant_o, !fetch_req_o);
    if (p_block && !p_req) check("R2 no fetch start while blocked", fetch_req_o, 0);
    if (p_fl) check("R7 empty after flush", avail_o, 0);
    took = 0;
    if (fl) begin
      exp_qs = 2;
      exp_pc = tgt;
    end else if (rd && avail_o) begin
      if (exp_pc == 16'hFFFF || exp_pc == 16'h0000)
        check("R11 wrapped byte", rd_byte_o, mbyte(exp_pc));
      else
        check("R5 oldest byte", rd_byte_o, mbyte(exp_pc));
      exp_pc++;
      exp_qs = first ? 1 : 3;
      took = 1;
    end else begin
      exp_qs = 0;
    end
    p_opr = opr; p_block = opr | fl; p_req = fetch_req_o; p_fl = fl;
    rd_i = rd; first_i = first; flush_i = fl; flush_addr_i = tgt; opr_req_i = opr;
  endtask

  logic [15:0] starts [4] = '{16'h0100, 16'h0101, 16'hFFFE, 16'hFFFF};

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    bit t;
    int n;
    repeat (3) @(negedge clk);
    check("R1 no fetch in reset", fetch_req_o, 0);
    check("R1 empty in reset", avail_o, 0);
    check("R1 status idle in reset", qs_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 first fetch pending", fetch_req_o, 1);
    check("R1 first fetch address", fetch_addr_o, 0);
    check("R1 first fetch is word", fetch_word_o, 1);
    exp_pc = 16'h0000;
    for (int i = 0; i < 12; i++) cyc(1'b1, (i % 2) == 0, 1'b0, '0, 1'b0, t);

    // Sweep start alignment and bus latency
    for (int l = 0; l < 4; l++) begin
      for (int s = 0; s < 4; s++) begin
        lat = l;
        cyc(1'b0, 1'b0, 1'b1, starts[s], 1'b0, t);
        repeat (30) cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, t);
        cyc(1'b0, 1'b0, 1'b0, '0, 1'b1, t);
        cyc(1'b0, 1'b0, 1'b0, '0, 1'b1, t);
        n = 0;
        forever begin
          cyc(1'b1, n == 0, 1'b0, '0, 1'b1, t);
          if (!t) break;
          n++;
        end
        check(starts[s][0] ? "R6 R4 fill from odd start" : "R6 R3 fill from even start",
              n, fill_of(starts[s]));
        for (int i = 0; i < 40; i++) cyc(1'b1, (i % 3) == 0, 1'b0, '0, 1'b0, t);
      end
    end

    // R8: flush while a fetch is in flight, with a read in the same cycle
    lat = 3;
    cyc(1'b0, 1'b0, 1'b1, 16'h0300, 1'b0, t);
    for (int i = 0; i < 10 && !fetch_req_o; i++) cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, t);
    cyc(1'b1, 1'b1, 1'b1, 16'h0400, 1'b0, t);
    for (int i = 0; i < 30; i++) cyc(1'b1, (i % 4) == 0, 1'b0, '0, 1'b0, t);

    // R9: operand request raised while a fetch is pending
    cyc(1'b0, 1'b0, 1'b1, 16'h0501, 1'b0, t);
    for (int i = 0; i < 10 && !fetch_req_o; i++) cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, t);
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, 1'b0, '0, 1'b1, t);
    check("R9 granted after fetch completed", opr_grant_o, 1);
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, t);
    cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, t);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule